// File: doc/BRIEF.md
# Delay Tracking Generator with Sample-Shift Carries

This block follows a slowly changing fractional sample delay for three data streams: two station streams and their baseline. Each stream has its own accumulator. On every clock the accumulator adds a signed rate to a 32-bit error word that holds the fractional part of the delay. When that sum wraps past the top or below zero, the block raises a one-cycle carry with a direction bit. The data path uses the carry to repeat or drop one sample.

Two channels drive commands one cycle after their carry. A carry on the first station asks the phase generator to skip (null) or repeat (double) one phase increment. A carry on the baseline steps the rotator phase by a quarter cycle up or down, and the block keeps a running count of those steps modulo four. The top bit of each error word is also brought out as a vernier tap-select bit. Software loads a rate and a starting error per channel. A channel whose rate and error are both zero produces no carries, which turns off everything downstream of it.

Top module: `delay_track_gen`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, every carry, direction, vernier, command strobe and the quadrant count are zero, and all rates and errors are zero.
- R2: On each clock where init_err of a channel is low, that channel's error becomes (error + sign-extended rate) mod 2^32. carry of that channel is high for exactly the cycle after the clock on which this sum wraps. Channel index 0 is station X, 1 is station Y and 2 is the baseline.
- R3: carry_dir is 0 for a wrap past the top with a non-negative rate, and 1 for a wrap below zero with a negative rate.
- R4: A rate written with set_rate is stored on the next clock. The accumulation on that same clock still uses the old rate, so the new rate is first added on the clock after.
- R5: init_err loads err_in into the channel's error on the next clock. That clock produces no carry and overrides the accumulation, including when init_err is held for several clocks.
- R6: A channel whose rate is zero never produces a carry, whatever its error value.
- R7: vernier bit i equals the most significant bit of channel i's error register.
- R8: One cycle after a channel-0 carry, x_null_inc pulses if its direction was 0, or x_dbl_inc pulses if it was 1. The two are never high together, and channel 1 and 2 carries produce neither.
- R9: One cycle after a channel-2 carry, ph_step pulses with ph_step_dn equal to that carry's direction. Carries on channels 0 and 1 produce no step.
- R10: ph_quad counts quarter-cycle phase steps modulo 2^QUAD_W (default 2 bits). It increments on an up step and decrements on a down step, in the same cycle that ph_step is high, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_rate | input | 3 | Per-channel rate load strobe |
| rate_in | input | 54 | Per-channel signed rate, channel i in bits [18i+17:18i] |
| init_err | input | 3 | Per-channel error load strobe |
| err_in | input | 96 | Per-channel starting error, channel i in bits [32i+31:32i] |
| carry | output | 3 | One-cycle sample-shift strobe per channel |
| carry_dir | output | 3 | Carry direction: 0 up (overflow), 1 down (underflow) |
| vernier | output | 3 | Vernier tap-select bit per channel |
| x_null_inc | output | 1 | Station X null phase-increment command |
| x_dbl_inc | output | 1 | Station X double phase-increment command |
| ph_step | output | 1 | Baseline quarter-cycle phase step strobe |
| ph_step_dn | output | 1 | Step direction: 1 subtracts a quarter cycle |
| ph_quad | output | 2 | Accumulated quarter-cycle phase offset |

## Verification
A corrupted error word or rate usually stays hidden. Its only early sign is the vernier bit. Otherwise it shows up as a carry that arrives one or more clocks too early or too late. A wrong wrap test shows up as a carry with the wrong direction, or as a carry on a channel whose rate is zero. To catch these, the bench works out the exact clock of every expected carry from the loaded error and rate. Any carry off by even one clock is reported. Errors in the command stage show up one clock after the carry, as a missing or wrong strobe or as a quadrant count that stops agreeing with the running total of steps.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // channel assignment of the three accumulators
    localparam int unsigned CH_X  = 0;
    localparam int unsigned CH_Y  = 1;
    localparam int unsigned CH_BL = 2;
    localparam int unsigned N_CH  = 3;

    // carry direction encoding
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/dtg_accum.sv
module dtg_accum #(
    parameter int unsigned ERR_W  = 32,
    parameter int unsigned RATE_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_rate,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              init_err,
    input  logic [ERR_W-1:0]  err_in,
    output logic              carry_o,
    output logic              dir_o,
    output logic [ERR_W-1:0]  err_o,
    output logic [RATE_W-1:0] rate_o
);
    // one guard bit above the error word exposes the wrap
    localparam int unsigned SUM_W = ERR_W + 1;
    localparam int unsigned EXT_W = SUM_W - RATE_W;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [RATE_W-1:0] rate;
        logic              carry;
        logic              dir;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] rate_ext;

    always_comb begin
        st_d     = st_q;
        st_d.carry = 1'b0;
        st_d.dir   = 1'b0;
        rate_ext = {{EXT_W{st_q.rate[RATE_W-1]}}, st_q.rate};
        sum_w    = {1'b0, st_q.err} + rate_ext;
        if (init_err) begin
            st_d.err = err_in;
        end else begin
            st_d.err   = sum_w[ERR_W-1:0];
            // guard bit set: overflow for a positive rate, borrow for a negative one
            st_d.carry = sum_w[ERR_W];
            st_d.dir   = sum_w[ERR_W] & st_q.rate[RATE_W-1];
        end
        if (set_rate) begin
            st_d.rate = rate_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_o = st_q.carry;
    assign dir_o   = st_q.dir;
    assign err_o   = st_q.err;
    assign rate_o  = st_q.rate;

endmodule

// File: rtl/dtg_step_ctl.sv
module dtg_step_ctl #(
    parameter int unsigned QUAD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_carry,
    input  logic              x_dir,
    input  logic              bl_carry,
    input  logic              bl_dir,
    output logic              x_null_inc,
    output logic              x_dbl_inc,
    output logic              ph_step,
    output logic              ph_step_dn,
    output logic [QUAD_W-1:0] ph_quad
);
    localparam logic [QUAD_W-1:0] ONE_Q = QUAD_W'(1);

    typedef struct packed {
        logic              x_null;
        logic              x_dbl;
        logic              step;
        logic              step_dn;
        logic [QUAD_W-1:0] quad;
    } step_state_t;

    step_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        // duplicated sample -> skip one increment, deleted sample -> add one extra
        st_d.x_null  = x_carry & ~x_dir;
        st_d.x_dbl   = x_carry & x_dir;
        st_d.step    = bl_carry;
        st_d.step_dn = bl_carry & bl_dir;
        if (bl_carry) begin
            st_d.quad = bl_dir ? (st_q.quad - ONE_Q) : (st_q.quad + ONE_Q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_null_inc = st_q.x_null;
    assign x_dbl_inc  = st_q.x_dbl;
    assign ph_step    = st_q.step;
    assign ph_step_dn = st_q.step_dn;
    assign ph_quad    = st_q.quad;

endmodule

// File: rtl/delay_track_gen.sv
module delay_track_gen
    import dtg_pkg::*;
#(
    parameter int unsigned ERR_W  = 32,
    parameter int unsigned RATE_W = 18,
    parameter int unsigned QUAD_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH-1:0]          set_rate,
    input  logic [N_CH*RATE_W-1:0]   rate_in,
    input  logic [N_CH-1:0]          init_err,
    input  logic [N_CH*ERR_W-1:0]    err_in,
    output logic [N_CH-1:0]          carry,
    output logic [N_CH-1:0]          carry_dir,
    output logic [N_CH-1:0]          vernier,
    output logic                     x_null_inc,
    output logic                     x_dbl_inc,
    output logic                     ph_step,
    output logic                     ph_step_dn,
    output logic [QUAD_W-1:0]        ph_quad
);
    logic [ERR_W-1:0]  err_vec  [N_CH];
    logic [RATE_W-1:0] rate_vec [N_CH];

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        dtg_accum #(
            .ERR_W  (ERR_W),
            .RATE_W (RATE_W)
        ) i_accum (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_rate (set_rate[ch]),
            .rate_in  (rate_in[ch*RATE_W +: RATE_W]),
            .init_err (init_err[ch]),
            .err_in   (err_in[ch*ERR_W +: ERR_W]),
            .carry_o  (carry[ch]),
            .dir_o    (carry_dir[ch]),
            .err_o    (err_vec[ch]),
            .rate_o   (rate_vec[ch])
        );
        assign vernier[ch] = err_vec[ch][ERR_W-1];
    end

    dtg_step_ctl #(
        .QUAD_W (QUAD_W)
    ) i_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .x_carry    (carry[CH_X]),
        .x_dir      (carry_dir[CH_X]),
        .bl_carry   (carry[CH_BL]),
        .bl_dir     (carry_dir[CH_BL]),
        .x_null_inc (x_null_inc),
        .x_dbl_inc  (x_dbl_inc),
        .ph_step    (ph_step),
        .ph_step_dn (ph_step_dn),
        .ph_quad    (ph_quad)
    );

endmodule

// File: rtl/delay_track_gen_chk.sv
module delay_track_gen_chk
    import dtg_pkg::*;
#(
    parameter int unsigned ERR_W  = 32,
    parameter int unsigned RATE_W = 18,
    parameter int unsigned QUAD_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_CH-1:0]        init_err,
    input logic [N_CH*ERR_W-1:0]  err_in,
    input logic [N_CH-1:0]        carry,
    input logic [N_CH-1:0]        carry_dir,
    input logic [ERR_W-1:0]       err_vec  [N_CH],
    input logic [RATE_W-1:0]      rate_vec [N_CH],
    input logic                   x_null_inc,
    input logic                   x_dbl_inc,
    input logic                   ph_step,
    input logic                   ph_step_dn,
    input logic [QUAD_W-1:0]      ph_quad
);
    localparam logic [QUAD_W-1:0] ONE_Q = QUAD_W'(1);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
        // R5: a load clock never carries
        p_init_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
            carry[ch] |-> !$past(init_err[ch]));
        // R5: the loaded value lands in the error register
        p_err_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(init_err[ch]) |-> err_vec[ch] == $past(err_in[ch*ERR_W +: ERR_W]));
        // R3: direction follows the sign of the rate that was added
        p_dir_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
            carry[ch] |-> carry_dir[ch] == $past(rate_vec[ch][RATE_W-1]));
        // R6: a zero rate never wraps
        p_zero_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            carry[ch] |-> $past(rate_vec[ch]) != '0);
    end

    // R8: never both station commands at once
    p_xinc_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({x_null_inc, x_dbl_inc}));
    // R8: a double increment follows a downward X carry
    p_xdbl_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        x_dbl_inc |-> $past(carry[CH_X] && carry_dir[CH_X]));
    // R8: a null increment follows an upward X carry
    p_xnull_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        x_null_inc |-> $past(carry[CH_X] && !carry_dir[CH_X]));
    // R9: a step follows a baseline carry with the same direction
    p_step_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ph_step |-> $past(carry[CH_BL]) && (ph_step_dn == $past(carry_dir[CH_BL])));
    // R10: quadrant moves by one in the step direction
    p_quad_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_step && !ph_step_dn) |-> (ph_quad - $past(ph_quad)) == ONE_Q);
    p_quad_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_step && ph_step_dn) |-> ($past(ph_quad) - ph_quad) == ONE_Q);
    // R10: quadrant holds without a step
    p_quad_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_step |-> $stable(ph_quad));

endmodule

bind delay_track_gen delay_track_gen_chk #(
    .ERR_W  (ERR_W),
    .RATE_W (RATE_W),
    .QUAD_W (QUAD_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_err   (init_err),
    .err_in     (err_in),
    .carry      (carry),
    .carry_dir  (carry_dir),
    .err_vec    (err_vec),
    .rate_vec   (rate_vec),
    .x_null_inc (x_null_inc),
    .x_dbl_inc  (x_dbl_inc),
    .ph_step    (ph_step),
    .ph_step_dn (ph_step_dn),
    .ph_quad    (ph_quad)
);

// File: tb/test_delay_track_gen.sv
module test_delay_track_gen;
    localparam int EW = 32;
    localparam int RW = 18;
    localparam int NC = 3;
    localparam int NS = 5;   // streams: 0..2 carries, 3 phase step, 4 X increment cmd

    typedef struct {
        int unsigned cyc;
        logic        dir;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     set_rate = '0;
    logic [NC*RW-1:0]  rate_in = '0;
    logic [NC-1:0]     init_err = '0;
    logic [NC*EW-1:0]  err_in = '0;
    logic [NC-1:0]     carry, carry_dir, vernier;
    logic              x_null_inc, x_dbl_inc, ph_step, ph_step_dn;
    logic [1:0]        ph_quad;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          mon_on = 0;
    bit          done = 0;
    logic [1:0]  exp_quad = 2'd0;
    exp_t        q_exp [NS][$];

    delay_track_gen i_delay_track_gen (
        .clk(clk), .rst_n(rst_n), .set_rate(set_rate), .rate_in(rate_in),
        .init_err(init_err), .err_in(err_in), .carry(carry), .carry_dir(carry_dir),
        .vernier(vernier), .x_null_inc(x_null_inc), .x_dbl_inc(x_dbl_inc),
        .ph_step(ph_step), .ph_step_dn(ph_step_dn), .ph_quad(ph_quad)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    function automatic string req_of(input int s);
        if (s < 3) return "R2/R3";
        if (s == 3) return "R9";
        return "R8";
    endfunction

    // number of accumulations until the wrap
    function automatic longint calc_k(input int r, input logic [31:0] e);
        longint le = {32'd0, e};
        if (r > 0) return ((64'd1 << 32) - le + r - 1) / r;
        return le / (-r) + 1;
    endfunction

    task automatic push_exp(input int ch, input int unsigned at, input logic dir);
        exp_t it;
        it.cyc = at; it.dir = dir;
        q_exp[ch].push_back(it);
        it.cyc = at + 1;
        if (ch == 0) q_exp[4].push_back(it);
        if (ch == 2) q_exp[3].push_back(it);
    endtask

    // driver: load rate and error on one clock, queue the expected carry
    task automatic load(input int ch, input int r, input logic [31:0] e);
        int unsigned c;
        @(negedge clk);
        set_rate[ch] = 1'b1; init_err[ch] = 1'b1;
        rate_in[ch*RW +: RW] = RW'(r);
        err_in[ch*EW +: EW] = e;
        c = cyc;
        if (r != 0) push_exp(ch, c + 1 + int'(calc_k(r, e)), r < 0);
        @(negedge clk);
        set_rate[ch] = 1'b0; init_err[ch] = 1'b0;
    endtask

    // monitor: compare each strobe stream against the queue
    always @(negedge clk) begin
        logic [NS-1:0] act, adir;
        exp_t e;
        bit exp_now;
        if (mon_on) begin
            act  = {x_null_inc | x_dbl_inc, ph_step, carry};
            adir = {x_dbl_inc, ph_step_dn, carry_dir};
            for (int s = 0; s < NS; s++) begin
                while (q_exp[s].size() > 0 && q_exp[s][0].cyc < cyc) begin
                    chk(0, req_of(s), "missed strobe", 0, 1);
                    void'(q_exp[s].pop_front());
                end
                exp_now = (q_exp[s].size() > 0) && (q_exp[s][0].cyc == cyc);
                if (exp_now) begin
                    e = q_exp[s].pop_front();
                    chk(act[s] == 1'b1, req_of(s), "strobe", act[s], 1);
                    if (act[s]) begin
                        chk(adir[s] == e.dir, (s < 3) ? "R3" : req_of(s), "direction", adir[s], e.dir);
                        if (s == 3) begin
                            exp_quad = e.dir ? exp_quad - 2'd1 : exp_quad + 2'd1;
                            chk(ph_quad == exp_quad, "R10", "quadrant", ph_quad, exp_quad);
                        end
                    end
                end else if (act[s]) begin
                    chk(0, (s < 3) ? "R2/R6" : req_of(s), "unexpected strobe", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned c;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({carry, carry_dir, vernier, x_null_inc, x_dbl_inc, ph_step, ph_step_dn, ph_quad} == '0,
            "R1", "outputs in reset", {carry, vernier}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({carry, carry_dir, vernier, x_null_inc, x_dbl_inc, ph_step, ph_step_dn, ph_quad} == '0,
            "R1", "outputs after reset", {carry, vernier}, 0);
        mon_on = 1;

        // R2 R8: X upward wrap after 4 additions, null increment
        load(0, 32'sh40, 32'hFFFF_FF00);
        chk(vernier == 3'b001, "R7", "vernier X high", vernier, 3'b001);
        repeat (10) @(negedge clk);
        load(0, 0, 0);

        // R3: Y downward wrap after 6 additions, no commands
        load(1, -48, 32'h0000_0100);
        repeat (12) @(negedge clk);
        load(1, 0, 0);

        // R9 R10: baseline down (quadrant wraps to 3), then two up steps
        load(2, -16, 32'h0000_0020);
        repeat (8) @(negedge clk);
        load(2, 0, 0);
        load(2, 32'sh1000, 32'hFFFF_F000);
        repeat (5) @(negedge clk);
        load(2, 0, 0);
        load(2, 131071, 32'hFFFF_0000);
        repeat (5) @(negedge clk);
        load(2, 0, 0);

        // R8: X downward wrap gives a double increment
        load(0, -7, 32'h0000_0014);
        repeat (8) @(negedge clk);
        load(0, 0, 0);

        // R4: rate set alone takes effect one clock later
        load(0, 0, 32'hFFFF_FF00);
        @(negedge clk);
        set_rate[0] = 1'b1; rate_in[0 +: RW] = RW'(64);
        c = cyc;
        push_exp(0, c + 1 + int'(calc_k(64, 32'hFFFF_FF00)), 1'b0);
        @(negedge clk);
        set_rate[0] = 1'b0;
        repeat (10) @(negedge clk);
        load(0, 0, 0);

        // R5: held load overrides accumulation
        @(negedge clk);
        set_rate[0] = 1'b1; init_err[0] = 1'b1;
        rate_in[0 +: RW] = RW'(1); err_in[0 +: EW] = 32'hFFFF_FFFF;
        @(negedge clk);
        set_rate[0] = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(carry[0] == 1'b0, "R5", "carry while loading", carry[0], 0);
        end
        init_err[0] = 1'b0;
        push_exp(0, cyc + 1, 1'b0);
        repeat (6) @(negedge clk);
        load(0, 0, 0);

        // R6 R7: zero rate with errors at the top never carries
        load(0, 0, 32'hFFFF_FFFF);
        load(1, 0, 32'hFFFF_FFFF);
        load(2, 0, 32'hFFFF_FFFF);
        chk(vernier == 3'b111, "R7", "vernier all high", vernier, 3'b111);
        repeat (30) begin
            @(negedge clk);
            chk(carry == '0 && !ph_step && !x_null_inc && !x_dbl_inc, "R6",
                "activity at zero rate", carry, 0);
        end
        load(0, 0, 0); load(1, 0, 0); load(2, 0, 0);
        chk(vernier == 3'b000, "R7", "vernier all low", vernier, 3'b000);

        repeat (5) @(negedge clk);
        chk(ph_quad == 2'd1, "R10", "final quadrant", ph_quad, 1);
        for (int s = 0; s < NS; s++)
            chk(q_exp[s].size() == 0, req_of(s), "pending expectations", q_exp[s].size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule